// File: doc/BRIEF.md
# Dual-Bank Block Guard and Read Source Selector

This block sits beside the command decoder of a two-bank NOR flash array that has 21 word-address bits. It turns the upper bits of a word address into a bank and a linear block number. The boot strap input places the eight small 4 KWord parameter blocks either at the top or at the bottom of the address space. The 63 remaining blocks are 32 KWord main blocks. The block also holds a protection bit for each protection group. It combines these bits with a write-protect level and a temporary-unprotect level, and from the result it decides whether a program request may go ahead.

A second function picks where a read to the addressed bank takes its data. The choices are the array, the status word, or the identification (auto-select) data. This follows which bank is busy, which bank has a failed operation pending, and which bank was put into identification mode. Only one bank may run a program or erase at a time. A request made while either bank is busy is turned away with a busy flag. A request to a locked block is dropped with no flag at all.

All outputs are registered and reflect the inputs of the previous clock edge. The state used for that edge is the state held before the edge.

Top module: `flash_bank_guard`

## Requirements
- R1: With `boot_top_i`=1, addresses 180000h-1FFFFFh give `bank_o`=0 (bank A) and 000000h-17FFFFh give `bank_o`=1 (bank B). Blocks are numbered 0-62 for the main blocks upward from 000000h, and 63-70 for the parameter blocks from 1F8000h.
- R2: With `boot_top_i`=0, addresses 000000h-07FFFFh give `bank_o`=0 (bank A) and 080000h-1FFFFFh give `bank_o`=1 (bank B). Blocks 0-7 are the parameter blocks from 000000h, and blocks 8-70 are the main blocks from 008000h.
- R3: Every output is registered. It shows the result for the inputs that were present at the preceding rising clock edge.
- R4: After reset, `bank_o`, `block_o`, `prog_ok_o`, `prog_busy_o` and `rd_sel_o` are 0, and no protection group is set.
- R5: A pulse on `prot_set_i` sets the protection bit of the addressed group. A program request to any block of a set group then gives `prog_ok_o`=0 and `prog_busy_o`=0. A pulse on `unprot_all_i` clears every group, and it wins over a `prot_set_i` in the same cycle.
- R6: A main-block group covers one 128 KWord span, which is four 32 KWord blocks (address bits 20:17). Each parameter block is a group of its own.
- R7: While `tmp_unprot_i`=1, blocks whose group bit is set may still be programmed.
- R8: While `wp_n_i`=0, the two outermost parameter blocks are locked even when `tmp_unprot_i`=1. With top boot these are 1FE000h-1FFFFFh, and with bottom boot they are 000000h-001FFFh. While `wp_n_i`=1, those blocks follow their group bit.
- R9: A program request while either bit of `busy_i` is set gives `prog_busy_o`=1 and `prog_ok_o`=0, whichever bank it targets.
- R10: `rd_sel_o` encodes 0 = array, 1 = status, 2 = auto-select. A read to a bank whose `busy_i` bit is set gives 1. A read to the other, idle bank gives 0.
- R11: A pulse on `err_i[b]` makes reads to bank b give status (1) until a pulse on `rd_reset_i`.
- R12: A pulse on `autosel_req_i` puts the addressed bank into auto-select mode, so reads to it give 2 and reads to the other bank stay at 0. `rd_reset_i` ends the mode. Status takes precedence over auto-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| boot_top_i | input | 1 | 1 = parameter blocks at the top, 0 = at the bottom |
| addr_i | input | 9 | Word address bits 20:12 |
| wp_n_i | input | 1 | Write-protect level, 0 locks the outermost two boot blocks |
| tmp_unprot_i | input | 1 | Temporary unprotect level |
| prot_set_i | input | 1 | Set the protection bit of the addressed group |
| unprot_all_i | input | 1 | Clear every protection bit |
| prog_req_i | input | 1 | Program request at the address |
| busy_i | input | 2 | Per-bank busy, bit 0 = bank A, bit 1 = bank B |
| err_i | input | 2 | Per-bank failure pulse |
| autosel_req_i | input | 1 | Enter auto-select mode for the addressed bank |
| rd_reset_i | input | 1 | Return all banks to array reads and clear failures |
| bank_o | output | 1 | Bank of the address, 0 = A, 1 = B |
| block_o | output | 7 | Linear block number |
| prog_ok_o | output | 1 | Program request accepted |
| prog_busy_o | output | 1 | Program request rejected because a bank is busy |
| rd_sel_o | output | 2 | Read data source for the addressed bank |

## Verification
A wrong protection bit shows up at the ports only when a later program request hits that group. Each protect or unprotect step is therefore followed at once by requests inside the group, next to it, and in a neighbouring block of the same group, all checked one cycle after they are made. A wrong failure or auto-select flag shows up as a wrong `rd_sel_o` on the next read to that bank, so reads to both banks follow every change of mode. Address decode faults appear at once on `bank_o`/`block_o` at the bank edges and at the edges of the parameter region, for both boot placements.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY   = 2'd0,
    SRC_STATUS  = 2'd1,
    SRC_AUTOSEL = 2'd2
  } rd_src_e;
endpackage

// File: rtl/fbg_addr_map.sv
module fbg_addr_map #(
  parameter int ADDR_W   = 21,
  parameter int MAIN_SH  = 15,
  parameter int PARAM_SH = 12,
  parameter int BANK_SH  = 19,
  parameter int GRP_SH   = 17,
  parameter int BLK_W    = 7,
  parameter int GRP_W    = 5
) (
  input  logic                       boot_top_i,
  input  logic [ADDR_W-1:PARAM_SH]   addr_i,
  output logic                       bank_o,
  output logic [BLK_W-1:0]           blk_o,
  output logic [GRP_W-1:0]           grp_o,
  output logic                       outer_o
);
  localparam int HI_W    = ADDR_W - MAIN_SH;
  localparam int PI_W    = MAIN_SH - PARAM_SH;
  localparam int N_PARAM = 1 << PI_W;
  localparam int N_MSLOT = 1 << HI_W;
  localparam int N_MGRP  = 1 << (ADDR_W - GRP_SH);

  logic [HI_W-1:0]           hi;
  logic [PI_W-1:0]           pidx;
  logic [ADDR_W-BANK_SH-1:0] bsel;
  logic [ADDR_W-GRP_SH-1:0]  gsel;
  logic                      in_param;

  assign hi   = addr_i[ADDR_W-1:MAIN_SH];
  assign pidx = addr_i[MAIN_SH-1:PARAM_SH];
  assign bsel = addr_i[ADDR_W-1:BANK_SH];
  assign gsel = addr_i[ADDR_W-1:GRP_SH];

  always_comb begin
    if (boot_top_i) begin
      in_param = &hi;
      bank_o   = ~(&bsel);
      outer_o  = in_param & (&pidx[PI_W-1:1]);
      blk_o    = in_param ? BLK_W'(N_MSLOT - 1) + BLK_W'(pidx) : BLK_W'(hi);
    end else begin
      in_param = (hi == '0);
      bank_o   = |bsel;
      outer_o  = in_param & (pidx[PI_W-1:1] == '0);
      blk_o    = in_param ? BLK_W'(pidx) : BLK_W'(N_PARAM - 1) + BLK_W'(hi);
    end
    grp_o = in_param ? GRP_W'(N_MGRP) + GRP_W'(pidx) : GRP_W'(gsel);
  end
endmodule

// File: rtl/fbg_prot_regs.sv
module fbg_prot_regs #(
  parameter int N_GRP = 24,
  parameter int GRP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             set_i,
  input  logic             clr_all_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             outer_i,
  input  logic             wp_n_i,
  input  logic             tmp_unprot_i,
  output logic             locked_o
);
  logic [N_GRP-1:0] prot_q, prot_d, grp_hot;
  logic             upd_en, grp_bit;

  always_comb begin
    for (int g = 0; g < N_GRP; g++) begin
      grp_hot[g] = (grp_i == GRP_W'(g));
    end
  end

  assign upd_en = set_i | clr_all_i;

  always_comb begin
    if (clr_all_i) prot_d = '0;
    else           prot_d = prot_q | grp_hot;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    prot_q <= '0;
    else if (upd_en) prot_q <= prot_d;
  end

  assign grp_bit  = |(prot_q & grp_hot);
  assign locked_o = (outer_i & ~wp_n_i) | (grp_bit & ~tmp_unprot_i);
endmodule

// File: rtl/fbg_read_route.sv
module fbg_read_route
  import fbg_pkg::*;
#(
  parameter int N_BANK = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              bank_i,
  input  logic [N_BANK-1:0] busy_i,
  input  logic [N_BANK-1:0] err_i,
  input  logic              rd_reset_i,
  input  logic              autosel_req_i,
  output rd_src_e           src_o
);
  logic [N_BANK-1:0] err_q, err_d, as_q, as_d, bank_hot;
  logic              upd_en;

  generate
    for (genvar b = 0; b < N_BANK; b++) begin : g_hot
      assign bank_hot[b] = (bank_i == 1'(b));
    end
  endgenerate

  assign upd_en = rd_reset_i | autosel_req_i | (|err_i);

  always_comb begin
    err_d = (rd_reset_i ? '0 : err_q) | err_i;
    as_d  = (rd_reset_i ? '0 : as_q) | (autosel_req_i ? bank_hot : '0);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      err_q <= '0;
      as_q  <= '0;
    end else if (upd_en) begin
      err_q <= err_d;
      as_q  <= as_d;
    end
  end

  always_comb begin
    if (|((busy_i | err_q) & bank_hot)) src_o = SRC_STATUS;
    else if (|(as_q & bank_hot))        src_o = SRC_AUTOSEL;
    else                                src_o = SRC_ARRAY;
  end
endmodule

// File: rtl/flash_bank_guard.sv
module flash_bank_guard
  import fbg_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int MAIN_SH  = 15,
  parameter int PARAM_SH = 12,
  parameter int BANK_SH  = 19,
  parameter int GRP_SH   = 17,
  localparam int N_PARAM = 1 << (MAIN_SH - PARAM_SH),
  localparam int N_MSLOT = 1 << (ADDR_W - MAIN_SH),
  localparam int BLK_W   = $clog2(N_MSLOT + N_PARAM - 1),
  localparam int N_GRP   = (1 << (ADDR_W - GRP_SH)) + N_PARAM,
  localparam int GRP_W   = $clog2(N_GRP)
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     boot_top_i,
  input  logic [ADDR_W-1:PARAM_SH] addr_i,
  input  logic                     wp_n_i,
  input  logic                     tmp_unprot_i,
  input  logic                     prot_set_i,
  input  logic                     unprot_all_i,
  input  logic                     prog_req_i,
  input  logic [1:0]               busy_i,
  input  logic [1:0]               err_i,
  input  logic                     autosel_req_i,
  input  logic                     rd_reset_i,
  output logic                     bank_o,
  output logic [BLK_W-1:0]         block_o,
  output logic                     prog_ok_o,
  output logic                     prog_busy_o,
  output logic [1:0]               rd_sel_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             bank_c, outer_c, locked_c;
  logic [BLK_W-1:0] blk_c;
  logic [GRP_W-1:0] grp_c;
  rd_src_e          src_c;
  logic             ok_d, busy_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= '0;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  fbg_addr_map #(
    .ADDR_W(ADDR_W), .MAIN_SH(MAIN_SH), .PARAM_SH(PARAM_SH),
    .BANK_SH(BANK_SH), .GRP_SH(GRP_SH), .BLK_W(BLK_W), .GRP_W(GRP_W)
  ) u_map (
    .boot_top_i(boot_top_i),
    .addr_i    (addr_i),
    .bank_o    (bank_c),
    .blk_o     (blk_c),
    .grp_o     (grp_c),
    .outer_o   (outer_c)
  );

  fbg_prot_regs #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_prot (
    .clk_i       (clk_i),
    .rst_n_i     (rst_sync_n),
    .set_i       (prot_set_i),
    .clr_all_i   (unprot_all_i),
    .grp_i       (grp_c),
    .outer_i     (outer_c),
    .wp_n_i      (wp_n_i),
    .tmp_unprot_i(tmp_unprot_i),
    .locked_o    (locked_c)
  );

  fbg_read_route #(.N_BANK(2)) u_route (
    .clk_i        (clk_i),
    .rst_n_i      (rst_sync_n),
    .bank_i       (bank_c),
    .busy_i       (busy_i),
    .err_i        (err_i),
    .rd_reset_i   (rd_reset_i),
    .autosel_req_i(autosel_req_i),
    .src_o        (src_c)
  );

  always_comb begin
    busy_d = prog_req_i & (|busy_i);
    ok_d   = prog_req_i & ~(|busy_i) & ~locked_c;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_o      <= 1'b0;
      block_o     <= '0;
      prog_ok_o   <= 1'b0;
      prog_busy_o <= 1'b0;
      rd_sel_o    <= 2'd0;
    end else begin
      bank_o      <= bank_c;
      block_o     <= blk_c;
      prog_ok_o   <= ok_d;
      prog_busy_o <= busy_d;
      rd_sel_o    <= src_c;
    end
  end
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int ADDR_W = 21,
  parameter int OUT_SH = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   boot_top,
  input logic [ADDR_W-1:OUT_SH] addr_hi,
  input logic                   wp_n,
  input logic                   prog_req,
  input logic [1:0]             busy,
  input logic                   bank,
  input logic                   prog_ok,
  input logic                   prog_busy,
  input logic [1:0]             rd_sel
);
  logic armed_q;
  logic outer_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign outer_now = boot_top ? (&addr_hi) : (addr_hi == '0);

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_ok && prog_busy));

  p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> $past(|busy));

  p_ok_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |-> $past(prog_req && !(|busy)));

  p_wp_outer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |-> !$past(!wp_n && outer_now));

  p_sel_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel != 2'd3);

  p_busy_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q) && $past(busy[bank]) && $stable(bank)) |-> (rd_sel == 2'd1));
endmodule

bind flash_bank_guard fbg_checker #(.ADDR_W(ADDR_W), .OUT_SH(PARAM_SH + 1)) u_fbg_chk (
  .clk      (clk_i),
  .rst_n    (rst_sync_n),
  .boot_top (boot_top_i),
  .addr_hi  (addr_i[ADDR_W-1:PARAM_SH+1]),
  .wp_n     (wp_n_i),
  .prog_req (prog_req_i),
  .busy     (busy_i),
  .bank     (bank_o),
  .prog_ok  (prog_ok_o),
  .prog_busy(prog_busy_o),
  .rd_sel   (rd_sel_o)
);

// File: tb/flash_bank_guard_tb_top.sv
`timescale 1ns/1ps
module flash_bank_guard_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_n_i;
  logic       boot_top_i, wp_n_i, tmp_unprot_i, prot_set_i, unprot_all_i;
  logic       prog_req_i, autosel_req_i, rd_reset_i;
  logic [1:0] busy_i, err_i;
  logic [20:0] full_addr;
  logic       bank_o, prog_ok_o, prog_busy_o;
  logic [6:0] block_o;
  logic [1:0] rd_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_bank_guard dut_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .boot_top_i(boot_top_i),
    .addr_i(full_addr[20:12]), .wp_n_i(wp_n_i), .tmp_unprot_i(tmp_unprot_i),
    .prot_set_i(prot_set_i), .unprot_all_i(unprot_all_i), .prog_req_i(prog_req_i),
    .busy_i(busy_i), .err_i(err_i), .autosel_req_i(autosel_req_i),
    .rd_reset_i(rd_reset_i), .bank_o(bank_o), .block_o(block_o),
    .prog_ok_o(prog_ok_o), .prog_busy_o(prog_busy_o), .rd_sel_o(rd_sel_o)
  );

  typedef struct packed {
    logic        boot;
    logic [20:0] addr;
    logic        bank;
    logic [6:0]  blk;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 21'h000000, 1'b1, 7'd0},
    '{1'b1, 21'h17FFFF, 1'b1, 7'd47},
    '{1'b1, 21'h180000, 1'b0, 7'd48},
    '{1'b1, 21'h1F0000, 1'b0, 7'd62},
    '{1'b1, 21'h1F8000, 1'b0, 7'd63},
    '{1'b1, 21'h1FFFFF, 1'b0, 7'd70},
    '{1'b0, 21'h000000, 1'b0, 7'd0},
    '{1'b0, 21'h007FFF, 1'b0, 7'd7},
    '{1'b0, 21'h008000, 1'b0, 7'd8},
    '{1'b0, 21'h07FFFF, 1'b0, 7'd22},
    '{1'b0, 21'h080000, 1'b1, 7'd23},
    '{1'b0, 21'h1FFFFF, 1'b1, 7'd70}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic try_prog(input logic [20:0] a, input string req,
                          input bit exp_ok, input bit exp_busy);
    full_addr  = a;
    prog_req_i = 1'b1;
    @(negedge clk_i);
    chk(req, prog_ok_o, exp_ok);
    chk(req, prog_busy_o, exp_busy);
    prog_req_i = 1'b0;
  endtask

  task automatic try_read(input logic [20:0] a, input string req, input int exp_sel);
    full_addr = a;
    @(negedge clk_i);
    chk(req, rd_sel_o, exp_sel);
  endtask

  task automatic protect(input logic [20:0] a);
    full_addr  = a;
    prot_set_i = 1'b1;
    @(negedge clk_i);
    prot_set_i = 1'b0;
  endtask

  task automatic clear_all();
    unprot_all_i = 1'b1;
    @(negedge clk_i);
    unprot_all_i = 1'b0;
  endtask

  task automatic pulse_rd_reset();
    rd_reset_i = 1'b1;
    @(negedge clk_i);
    rd_reset_i = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n_i = 1'b0; boot_top_i = 1'b1; full_addr = 21'h1FFFFF;
    wp_n_i = 1'b1; tmp_unprot_i = 1'b0; prot_set_i = 1'b0; unprot_all_i = 1'b0;
    prog_req_i = 1'b1; busy_i = 2'b00; err_i = 2'b00;
    autosel_req_i = 1'b0; rd_reset_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R4: reset values while reset is held
    chk("R4 bank", bank_o, 0);
    chk("R4 block", block_o, 0);
    chk("R4 ok", prog_ok_o, 0);
    chk("R4 sel", rd_sel_o, 0);
    prog_req_i = 1'b0;
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R4 idle ok", prog_ok_o, 0);

    // R1 R2 R3: address decode table, result one edge later
    for (int i = 0; i < 12; i++) begin
      boot_top_i = VEC[i].boot;
      full_addr  = VEC[i].addr;
      @(negedge clk_i);
      chk(VEC[i].boot ? "R1 bank" : "R2 bank", bank_o, VEC[i].bank);
      chk(VEC[i].boot ? "R1 block" : "R2 block", block_o, VEC[i].blk);
    end

    // R3: output still shows the previous address right after a change
    boot_top_i = 1'b1;
    full_addr = 21'h000000;
    @(negedge clk_i);
    full_addr = 21'h1FF000;
    #1 chk("R3 latency", block_o, 0);
    @(negedge clk_i);
    chk("R3 updated", block_o, 70);

    // R4: no group set after reset
    try_prog(21'h1FF000, "R4 no prot", 1, 0);

    // R5 R6 R7: protection groups, top boot
    try_prog(21'h010000, "R5 before", 1, 0);
    protect(21'h010000);
    try_prog(21'h010000, "R5 dropped", 0, 0);
    try_prog(21'h018000, "R6 same group", 0, 0);
    try_prog(21'h000000, "R6 same group low", 0, 0);
    try_prog(21'h020000, "R6 next group", 1, 0);
    tmp_unprot_i = 1'b1;
    try_prog(21'h010000, "R7 temp unprotect", 1, 0);
    tmp_unprot_i = 1'b0;
    clear_all();
    try_prog(21'h010000, "R5 cleared", 1, 0);
    // R5: clear wins over set in the same cycle
    full_addr = 21'h040000; prot_set_i = 1'b1; unprot_all_i = 1'b1;
    @(negedge clk_i);
    prot_set_i = 1'b0; unprot_all_i = 1'b0;
    try_prog(21'h040000, "R5 clear wins", 1, 0);
    // R6: parameter block groups are single blocks
    protect(21'h1F8000);
    try_prog(21'h1F8000, "R6 param locked", 0, 0);
    try_prog(21'h1F9000, "R6 param neighbour", 1, 0);
    clear_all();

    // R8: write protect on the outermost boot blocks
    wp_n_i = 1'b0;
    try_prog(21'h1FE000, "R8 top outer", 0, 0);
    try_prog(21'h1FF000, "R8 top outer2", 0, 0);
    try_prog(21'h1FD000, "R8 top inner", 1, 0);
    tmp_unprot_i = 1'b1;
    try_prog(21'h1FE000, "R8 overrides temp", 0, 0);
    tmp_unprot_i = 1'b0;
    boot_top_i = 1'b0;
    try_prog(21'h001000, "R8 bottom outer", 0, 0);
    try_prog(21'h002000, "R8 bottom inner", 1, 0);
    try_prog(21'h1FF000, "R8 bottom far end", 1, 0);
    wp_n_i = 1'b1;
    try_prog(21'h001000, "R8 released", 1, 0);
    protect(21'h001000);
    try_prog(21'h001000, "R8 follows bit", 0, 0);
    clear_all();
    boot_top_i = 1'b1;

    // R9: busy rejection
    busy_i = 2'b01;
    try_prog(21'h000000, "R9 other bank", 0, 1);
    try_prog(21'h180000, "R9 same bank", 0, 1);
    // R10: read routing while bank A busy
    try_read(21'h180000, "R10 busy bank", 1);
    try_read(21'h000000, "R10 idle bank", 0);
    busy_i = 2'b00;
    try_prog(21'h000000, "R9 idle again", 1, 0);

    // R11: failure hold on bank B
    err_i = 2'b10;
    @(negedge clk_i);
    err_i = 2'b00;
    try_read(21'h000000, "R11 failed bank", 1);
    try_read(21'h180000, "R11 other bank", 0);
    try_read(21'h000000, "R11 still held", 1);
    pulse_rd_reset();
    try_read(21'h000000, "R11 after reset", 0);

    // R12: auto-select on bank A
    full_addr = 21'h180000; autosel_req_i = 1'b1;
    @(negedge clk_i);
    autosel_req_i = 1'b0;
    try_read(21'h180000, "R12 autosel bank", 2);
    try_read(21'h000000, "R12 other bank", 0);
    busy_i = 2'b01;
    try_read(21'h180000, "R12 status first", 1);
    busy_i = 2'b00;
    try_read(21'h180000, "R12 back to autosel", 2);
    pulse_rd_reset();
    try_read(21'h180000, "R12 after reset", 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule